// File: doc/BRIEF.md
# Crypto Request Chunking Sequencer

The sequencer accepts one cipher request (source address, destination address, byte length) and turns it into a series of engine jobs. No job is larger than a fixed byte cap. For each job it sends four command words, one at a time, to a downstream command-queue port that uses a valid/ready handshake. It sends the first three words straight away. It keeps the fourth word, which closes the transfer, until the engine reports completion. If completion does not come within a cycle budget, the request ends with an error and the remaining jobs are dropped.

A request can also ask for an IV-load job first. This is a single block, read from a separate IV address, with IV update turned off. The data jobs then follow with IV update turned on. While each job runs, the destination address for that job is shown on a side output. A request finishes with a one-cycle done pulse, and an error flag goes with it.

Top module: `cipher_job_seq`

## Requirements
- R1: A request is split into successive jobs of at most MAX_JOB_BYTES (16384 by default) bytes. Each job's input address is the previous job's address plus the previous job's byte count.
- R2: A job's block count is its byte count divided by 16, rounded up. The block-start word carries this count minus one in bits [CNT_W-1:0] (bits [9:0] by default).
- R3: Each job sends four words in this order: a setup word (opcode 0x10 in bits [31:26], all other bits zero), the job's input address, the block-start word (opcode 0x0E in bits [31:26]), and the close word (opcode 0x11 in bits [31:26], all other bits zero).
- R4: The close word is offered only after `cmpl_i` has pulsed for that job.
- R5: No word is offered while `eng_busy_i` is high and `cq_empty_i` is low.
- R6: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` stays high and `cmd_word_o` stays unchanged on the next cycle.
- R7: If `cmpl_i` does not arrive within TIMEOUT_CYC cycles of the block-start word being accepted, the request ends with an error. The close word is not sent and no further job is started.
- R8: When `req_iv_i` is set, a one-block job using `req_iv_addr_i` runs first with `job_iv_upd_o`=0. Data jobs always run with `job_iv_upd_o`=1.
- R9: A request is accepted only while `req_ready_o` is high. `req_ready_o` is low from the accepting cycle until the done pulse, and requests offered in that window have no effect.
- R10: `done_o` is a pulse one cycle long. `err_o` is high only together with `done_o`.
- R11: After reset, `req_ready_o`=1, `cmd_valid_o`=0 and `done_o`=0.
- R12: A zero-length request without an IV load finishes with `done_o` and `err_o`=0, and no word is sent.
- R13: During each data job, `job_dst_o` holds the request destination plus the bytes of all earlier jobs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle; the request is taken this cycle |
| req_src_i | input | AW | Source byte address |
| req_dst_i | input | AW | Destination byte address |
| req_len_i | input | LW | Request length in bytes |
| req_iv_i | input | 1 | Run an IV-load job first |
| req_iv_addr_i | input | AW | Address of the IV block |
| cmd_valid_o | output | 1 | Command word offered |
| cmd_ready_i | input | 1 | Queue takes the word |
| cmd_word_o | output | 32 | Command word |
| job_dst_o | output | AW | Destination of the current job |
| job_iv_upd_o | output | 1 | IV update enable for the current job |
| eng_busy_i | input | 1 | Engine busy |
| cq_empty_i | input | 1 | Command queue empty |
| cmpl_i | input | 1 | Job completion pulse |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 1 | Request ended by timeout, valid with done_o |

## Verification
The bound checker watches the cycle-level rules on every cycle: the handshake holds under backpressure, no word is offered while the engine is busy and the queue is non-empty, the close word follows a completion pulse, done is a single-cycle pulse and the error flag comes only with it, and the request port closes once a request is accepted. Several behaviours can only be shown by the directed scenarios, because they depend on the contents of a whole word stream. These are splitting at the 16 KiB cap, ceiling rounding of the block count, address and destination stepping, the IV-load job that comes first, skipping the remaining jobs after a timeout, and the finish with no words on a zero-length request.

// File: rtl/cjs_pkg.sv
package cjs_pkg;
  localparam int unsigned CMD_W  = 32;
  localparam int unsigned OP_LSB = 26;

  localparam logic [5:0] OP_SETUP = 6'h10;
  localparam logic [5:0] OP_START = 6'h0E;
  localparam logic [5:0] OP_CLOSE = 6'h11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_START, ST_WAIT, ST_CLOSE, ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    WSEL_SETUP, WSEL_ADDR, WSEL_START, WSEL_CLOSE
  } word_sel_e;
endpackage

// File: rtl/cjs_splitter.sv
module cjs_splitter #(
  parameter int unsigned AW            = 32,
  parameter int unsigned LW            = 24,
  parameter int unsigned MAX_JOB_BYTES = 16384,
  parameter int unsigned BLK_BYTES     = 16,
  parameter int unsigned CNT_W         = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [LW-1:0]    len_i,
  input  logic             adv_i,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CNT_W-1:0] nblk_m1_o,
  output logic             last_o,
  output logic             empty_o
);
  localparam int unsigned BLK_SH = $clog2(BLK_BYTES);
  localparam logic [LW-1:0] MAX_L = LW'(MAX_JOB_BYTES);
  localparam logic [LW-1:0] RND_L = LW'(BLK_BYTES - 1);

  logic [LW-1:0] rem_q;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] job_bytes, nblk;

  assign job_bytes = (rem_q > MAX_L) ? MAX_L : rem_q;
  assign nblk      = (job_bytes + RND_L) >> BLK_SH;   // ceiling division
  assign nblk_m1_o = CNT_W'(nblk - LW'(1));
  assign last_o    = (rem_q <= MAX_L);
  assign empty_o   = (rem_q == '0);
  assign src_o     = src_q;
  assign dst_o     = dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (load_i) begin
      rem_q <= len_i;
      src_q <= src_i;
      dst_q <= dst_i;
    end else if (adv_i) begin
      rem_q <= rem_q - job_bytes;
      src_q <= src_q + AW'(job_bytes);
      dst_q <= dst_q + AW'(job_bytes);
    end
  end
endmodule

// File: rtl/cjs_timer.sv
module cjs_timer #(
  parameter int unsigned TIMEOUT_CYC = 7_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/cjs_cmd_fmt.sv
module cjs_cmd_fmt
  import cjs_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 10
) (
  input  word_sel_e         sel_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CNT_W-1:0]  nblk_m1_i,
  output logic [CMD_W-1:0]  word_o
);
  logic [CMD_W-1:0] addr_w;

  generate
    if (AW >= CMD_W) begin : g_addr_trunc
      assign addr_w = addr_i[CMD_W-1:0];
    end else begin : g_addr_ext
      assign addr_w = {{(CMD_W-AW){1'b0}}, addr_i};
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      WSEL_SETUP: word_o = {OP_SETUP, {OP_LSB{1'b0}}};
      WSEL_ADDR:  word_o = addr_w;
      WSEL_START: word_o = {OP_START, {(OP_LSB-CNT_W){1'b0}}, nblk_m1_i};
      default:    word_o = {OP_CLOSE, {OP_LSB{1'b0}}};
    endcase
  end
endmodule

// File: rtl/cipher_job_seq.sv
module cipher_job_seq
  import cjs_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned LW            = 24,
  parameter int unsigned MAX_JOB_BYTES = 16384,
  parameter int unsigned BLK_BYTES     = 16,
  parameter int unsigned TIMEOUT_CYC   = 7_500_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_src_i,
  input  logic [AW-1:0]    req_dst_i,
  input  logic [LW-1:0]    req_len_i,
  input  logic             req_iv_i,
  input  logic [AW-1:0]    req_iv_addr_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [31:0]      cmd_word_o,
  output logic [AW-1:0]    job_dst_o,
  output logic             job_iv_upd_o,
  input  logic             eng_busy_i,
  input  logic             cq_empty_i,
  input  logic             cmpl_i,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned RAW_CW = $clog2(MAX_JOB_BYTES / BLK_BYTES);
  localparam int unsigned CNT_W  = (RAW_CW < 1) ? 1 : RAW_CW;

  seq_state_e state_q;
  logic       offer_q, iv_phase_q, err_q;
  logic [AW-1:0] iv_addr_q;

  logic [AW-1:0]    sp_src, sp_dst;
  logic [CNT_W-1:0] sp_nblk_m1;
  logic             sp_last, sp_empty;
  logic             accept, gate_ok, hs, word_state, adv, expired;
  word_sel_e        sel;
  logic [AW-1:0]    job_addr;
  logic [CNT_W-1:0] job_nblk_m1;

  assign accept     = req_valid_i && (state_q == ST_IDLE);
  assign gate_ok    = !(eng_busy_i && !cq_empty_i);
  assign hs         = offer_q && cmd_ready_i;
  assign word_state = (state_q == ST_SETUP) || (state_q == ST_ADDR) ||
                      (state_q == ST_START) || (state_q == ST_CLOSE);
  assign adv        = hs && (state_q == ST_CLOSE) && !iv_phase_q;

  always_comb begin
    unique case (state_q)
      ST_SETUP: sel = WSEL_SETUP;
      ST_ADDR:  sel = WSEL_ADDR;
      ST_START: sel = WSEL_START;
      default:  sel = WSEL_CLOSE;
    endcase
  end

  assign job_addr    = iv_phase_q ? iv_addr_q : sp_src;
  assign job_nblk_m1 = iv_phase_q ? '0 : sp_nblk_m1;

  cjs_splitter #(
    .AW(AW), .LW(LW), .MAX_JOB_BYTES(MAX_JOB_BYTES),
    .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)
  ) i_split (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .src_i     (req_src_i),
    .dst_i     (req_dst_i),
    .len_i     (req_len_i),
    .adv_i     (adv),
    .src_o     (sp_src),
    .dst_o     (sp_dst),
    .nblk_m1_o (sp_nblk_m1),
    .last_o    (sp_last),
    .empty_o   (sp_empty)
  );

  cjs_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_WAIT),
    .expired_o (expired)
  );

  cjs_cmd_fmt #(.AW(AW), .CNT_W(CNT_W)) i_fmt (
    .sel_i     (sel),
    .addr_i    (job_addr),
    .nblk_m1_i (job_nblk_m1),
    .word_o    (cmd_word_o)
  );

  // offer is latched once the gate opens so valid never drops before accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) offer_q <= 1'b0;
    else if (hs) offer_q <= 1'b0;
    else if (word_state && gate_ok) offer_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      iv_phase_q <= 1'b0;
      iv_addr_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          iv_phase_q <= req_iv_i;
          iv_addr_q  <= req_iv_addr_i;
          err_q      <= 1'b0;
          state_q    <= (req_iv_i || (req_len_i != '0)) ? ST_SETUP : ST_FIN;
        end
        ST_SETUP: if (hs) state_q <= ST_ADDR;
        ST_ADDR:  if (hs) state_q <= ST_START;
        ST_START: if (hs) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (cmpl_i) state_q <= ST_CLOSE;
          else if (expired) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end
        end
        ST_CLOSE: if (hs) begin
          if (iv_phase_q) begin
            iv_phase_q <= 1'b0;
            state_q    <= sp_empty ? ST_FIN : ST_SETUP;
          end else begin
            state_q    <= sp_last ? ST_FIN : ST_SETUP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign cmd_valid_o  = offer_q;
  assign job_dst_o    = sp_dst;
  assign job_iv_upd_o = !iv_phase_q;
  assign done_o       = (state_q == ST_FIN);
  assign err_o        = (state_q == ST_FIN) && err_q;
endmodule

// File: rtl/cjs_checker.sv
module cjs_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [31:0] cmd_word_o,
  input logic        eng_busy_i,
  input logic        cq_empty_i,
  input logic        cmpl_i,
  input logic        done_o,
  input logic        err_o
);
  logic seen_cmpl_q;
  logic close_hs;

  assign close_hs = cmd_valid_o && cmd_ready_i && (cmd_word_o[31:26] == 6'h11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_cmpl_q <= 1'b0;
    else if (cmpl_i)   seen_cmpl_q <= 1'b1;
    else if (close_hs) seen_cmpl_q <= 1'b0;
  end

  assert_close_after_cmpl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_hs |-> seen_cmpl_q);

  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(!(eng_busy_i && !cq_empty_i)));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));

  assert_busy_refuse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind cipher_job_seq cjs_checker i_cjs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_word_o  (cmd_word_o),
  .eng_busy_i  (eng_busy_i),
  .cq_empty_i  (cq_empty_i),
  .cmpl_i      (cmpl_i),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_cipher_job_seq.sv
module test_cipher_job_seq;
  localparam int AW = 32;
  localparam int LW = 24;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [AW-1:0] req_src_i = '0, req_dst_i = '0, req_iv_addr_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic req_iv_i = 1'b0;
  logic cmd_valid_o, cmd_ready_i = 1'b1;
  logic [31:0] cmd_word_o;
  logic [AW-1:0] job_dst_o;
  logic job_iv_upd_o;
  logic eng_busy_i = 1'b0, cq_empty_i = 1'b1, cmpl_i = 1'b0;
  logic done_o, err_o;

  int total = 0, bad = 0;
  int wcount = 0;
  logic [31:0]   wq [0:255];
  logic [AW-1:0] dq [0:255];
  logic          uq [0:255];
  int  ccnt = 0;
  bit  auto_cmpl = 1'b1;
  int  cmpl_delay = 3;

  always #10 clk = ~clk;

  cipher_job_seq #(.AW(AW), .LW(LW), .TIMEOUT_CYC(TMO)) i_cipher_job_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_src_i(req_src_i), .req_dst_i(req_dst_i), .req_len_i(req_len_i),
    .req_iv_i(req_iv_i), .req_iv_addr_i(req_iv_addr_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o),
    .job_dst_o(job_dst_o), .job_iv_upd_o(job_iv_upd_o),
    .eng_busy_i(eng_busy_i), .cq_empty_i(cq_empty_i), .cmpl_i(cmpl_i),
    .done_o(done_o), .err_o(err_o)
  );

  // word monitor and completion responder
  always @(posedge clk) begin
    if (rst_ni && cmd_valid_o && cmd_ready_i) begin
      wq[wcount % 256] <= cmd_word_o;
      dq[wcount % 256] <= job_dst_o;
      uq[wcount % 256] <= job_iv_upd_o;
      wcount <= wcount + 1;
      if (cmd_word_o[31:26] == 6'h0E && auto_cmpl) ccnt <= cmpl_delay;
    end else if (ccnt > 0) ccnt <= ccnt - 1;
  end
  always @(negedge clk) cmpl_i <= (ccnt == 1);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] start_w(input int nblk);
    return {6'h0E, 26'(nblk - 1)};
  endfunction

  task automatic send_req(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input int len, input bit iv, input logic [AW-1:0] iva);
    @(negedge clk);
    req_src_i = src; req_dst_i = dst; req_len_i = LW'(len);
    req_iv_i = iv; req_iv_addr_i = iva; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done(output bit e);
    e = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (done_o) begin
        e = err_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done one cycle", 64'(done_o), 64'd0);
        return;
      end
      @(negedge clk);
    end
    chk(1'b0, "R10 done never seen", 64'd0, 64'd1);
  endtask

  task automatic chk_job(input int idx, input logic [31:0] addr, input int nblk,
                         input logic [AW-1:0] dst, input bit upd, input string req);
    chk(wq[idx % 256] == 32'h4000_0000, {req, " R3 setup"}, 64'(wq[idx % 256]), 64'h4000_0000);
    chk(wq[(idx+1) % 256] == addr, {req, " R3 addr"}, 64'(wq[(idx+1) % 256]), 64'(addr));
    chk(wq[(idx+2) % 256] == start_w(nblk), {req, " R2 start"}, 64'(wq[(idx+2) % 256]), 64'(start_w(nblk)));
    chk(wq[(idx+3) % 256] == 32'h4400_0000, {req, " R3 close"}, 64'(wq[(idx+3) % 256]), 64'h4400_0000);
    chk(dq[(idx+1) % 256] == dst, {req, " R13 dst"}, 64'(dq[(idx+1) % 256]), 64'(dst));
    chk(uq[(idx+1) % 256] == upd, {req, " R8 iv_upd"}, 64'(uq[(idx+1) % 256]), 64'(upd));
  endtask

  task automatic t_reset;
    chk(req_ready_o == 1'b1, "R11 ready", 64'(req_ready_o), 64'd1);
    chk(cmd_valid_o == 1'b0, "R11 valid", 64'(cmd_valid_o), 64'd0);
    chk(done_o == 1'b0, "R11 done", 64'(done_o), 64'd0);
  endtask

  task automatic t_single;
    int b = wcount; bit e;
    cmpl_delay = 20;
    send_req(32'h1000, 32'h8000, 40, 1'b0, '0);
    while (wcount < b + 3) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(wcount == b + 3, "R4 close held", 64'(wcount - b), 64'd3);
    chk(cmd_valid_o == 1'b0, "R4 no offer", 64'(cmd_valid_o), 64'd0);
    wait_done(e);
    chk(e == 1'b0, "R10 err", 64'(e), 64'd0);
    chk(wcount == b + 4, "R3 count", 64'(wcount - b), 64'd4);
    chk_job(b, 32'h1000, 3, 32'h8000, 1'b1, "single");
    cmpl_delay = 3;
  endtask

  task automatic t_split;
    int b = wcount; bit e;
    send_req(32'h10000, 32'h40000, 2 * 16384 + 20, 1'b0, '0);
    wait_done(e);
    chk(wcount == b + 12, "R1 words", 64'(wcount - b), 64'd12);
    chk_job(b,     32'h10000, 1024, 32'h40000, 1'b1, "R1 job0");
    chk_job(b + 4, 32'h14000, 1024, 32'h44000, 1'b1, "R1 job1");
    chk_job(b + 8, 32'h18000, 2,    32'h48000, 1'b1, "R1 job2");
  endtask

  task automatic t_iv;
    int b = wcount; bit e;
    send_req(32'h3000, 32'h9000, 16, 1'b1, 32'h2000);
    wait_done(e);
    chk(wcount == b + 8, "R8 words", 64'(wcount - b), 64'd8);
    chk_job(b,     32'h2000, 1, 32'h9000, 1'b0, "R8 iv job");
    chk_job(b + 4, 32'h3000, 1, 32'h9000, 1'b1, "R8 data job");
  endtask

  task automatic t_gate;
    int b = wcount; bit e;
    @(negedge clk);
    eng_busy_i = 1'b1; cq_empty_i = 1'b0;
    send_req(32'h5000, 32'hA000, 32, 1'b0, '0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cmd_valid_o) break;
    end
    chk(cmd_valid_o == 1'b0, "R5 gated", 64'(cmd_valid_o), 64'd0);
    chk(wcount == b, "R5 no words", 64'(wcount - b), 64'd0);
    cq_empty_i = 1'b1;
    wait_done(e);
    eng_busy_i = 1'b0;
    chk(wcount == b + 4, "R5 resumed", 64'(wcount - b), 64'd4);
  endtask

  task automatic t_backpressure;
    int b = wcount; bit e;
    cmd_ready_i = 1'b0;
    send_req(32'h7000, 32'hB000, 16, 1'b0, '0);
    repeat (3) @(negedge clk);
    chk(cmd_valid_o == 1'b1, "R6 valid", 64'(cmd_valid_o), 64'd1);
    chk(cmd_word_o == 32'h4000_0000, "R6 word", 64'(cmd_word_o), 64'h4000_0000);
    repeat (4) @(negedge clk);
    chk(cmd_valid_o == 1'b1 && cmd_word_o == 32'h4000_0000, "R6 held", 64'(cmd_word_o), 64'h4000_0000);
    cmd_ready_i = 1'b1;
    wait_done(e);
    chk(wcount == b + 4, "R6 words", 64'(wcount - b), 64'd4);
    chk_job(b, 32'h7000, 1, 32'hB000, 1'b1, "R6");
  endtask

  task automatic t_timeout;
    int b = wcount; bit e;
    auto_cmpl = 1'b0;
    send_req(32'h20000, 32'h60000, 20000, 1'b0, '0);
    wait_done(e);
    chk(e == 1'b1, "R7 err", 64'(e), 64'd1);
    repeat (10) @(negedge clk);
    chk(wcount == b + 3, "R7 no close no next", 64'(wcount - b), 64'd3);
    chk(wq[(b+2) % 256] == start_w(1024), "R7 start", 64'(wq[(b+2) % 256]), 64'(start_w(1024)));
    auto_cmpl = 1'b1;
  endtask

  task automatic t_refuse;
    int b = wcount; bit e;
    send_req(32'h3300, 32'hC000, 20, 1'b0, '0);
    req_src_i = 32'h5500; req_len_i = 24'd20; req_valid_i = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b0, "R9 busy", 64'(req_ready_o), 64'd0);
    @(negedge clk);
    req_valid_i = 1'b0;
    wait_done(e);
    repeat (6) @(negedge clk);
    chk(wcount == b + 4, "R9 one request", 64'(wcount - b), 64'd4);
    chk(wq[(b+1) % 256] == 32'h3300, "R9 first addr", 64'(wq[(b+1) % 256]), 64'h3300);
  endtask

  task automatic t_zero;
    int b = wcount; bit e;
    send_req(32'h100, 32'h200, 0, 1'b0, '0);
    wait_done(e);
    chk(e == 1'b0, "R12 err", 64'(e), 64'd0);
    chk(wcount == b, "R12 no words", 64'(wcount - b), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_iv();
    t_gate();
    t_backpressure();
    t_timeout();
    t_refuse();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule